// File: doc/BRIEF.md
# Byte-Mapped GPIO Pin Controller

The controller presents a 48-byte register window on a byte-wide bus with one access per cycle. Its lower eight bytes are a read-only view of a level bank that a neighbouring block fills. The next 36 bytes are one control byte per pin. In each control byte, bit 2 enables the output driver, bit 0 is the value driven, and bit 1 is the pin's input level. When the driver is enabled, a bus write loops the written output value back into bit 1. The remaining bits of the control byte are stored exactly as written.

External logic reports input changes as single-cycle events that carry a pin number and a level. Two pins are tied to interrupt lines. The first gives an active-low level interrupt. The second follows its level directly and can also be pulsed for one cycle by a non-maskable interrupt request. If an input event arrives for a pin whose driver is enabled, a sticky error output is raised.

Top module: `gpio_pinctl`

## Requirements
- R1: After reset, every control byte reads 0x00 except pin 1, which reads 0x02. Also after reset irq_low, irq_nmi and err_flag are 0, and pin_oe and pin_do are all zero.
- R2: A read of offsets 0 to 7 returns byte k of lvl_bank (bits 8k+7 down to 8k). Bus writes to these offsets change no control byte.
- R3: Offset 8+p addresses the control byte of pin p, for p from 0 to 35. bus_rdata shows the addressed byte in the cycle after bus_rd and holds it until the next read.
- R4: A bus write to pin p stores the written byte with bit 1 replaced. If written bit 2 is 1, bit 1 becomes written bit 0. Otherwise bit 1 keeps its old value. pin_oe[p] and pin_do[p] show bits 2 and 0.
- R5: An input event (in_set high, with in_pin and in_val) sets only bit 1 of the addressed pin to in_val. An event with the same level leaves the byte unchanged. An event whose in_pin is 36 or higher has no effect.
- R6: irq_low is the inverse of bit 1 of pin 1.
- R7: irq_nmi equals bit 1 of pin 9.
- R8: A cycle with nmi_req high sets bit 1 of pin 9 to 1 at the next edge and back to 0 at the edge after that, giving a one-cycle pulse on irq_nmi.
- R9: Reads of offsets 44 and above return 0x00. Writes to them change nothing.
- R10: err_flag becomes 1 after an input event on a pin whose bit 2 is set. After that it stays 1 until reset.
- R11: When several sources update bit 1 of the same pin in the same cycle, a bus write takes precedence over the non-maskable pulse phase, and that phase takes precedence over an input event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| lvl_bank | input | 64 | Level bank bytes, byte k at bits 8k+7:8k |
| in_set | input | 1 | Input level event strobe |
| in_pin | input | 6 | Pin number of the event |
| in_val | input | 1 | New input level |
| nmi_req | input | 1 | Non-maskable interrupt request |
| pin_oe | output | 36 | Per-pin output enable (bit 2) |
| pin_do | output | 36 | Per-pin output value (bit 0) |
| irq_low | output | 1 | Active-low level interrupt of pin 1 |
| irq_nmi | output | 1 | Interrupt following pin 9 |
| err_flag | output | 1 | Sticky input-on-output error |

## Verification
The assertions check the following on every cycle: a write with the enable bit set to pin 1 or pin 9 drives the matching interrupt to the written value on the next edge, and a write to the level bank or to the tail region leaves pin_oe and pin_do unchanged. They also check that the tail region reads zero, that the non-maskable pulse drops one cycle after it rises unless a write intervenes, and that err_flag never falls. Some behaviours only the directed scenarios can show. These are the exact byte stored by loopback versus keep writes, the byte held when an input event repeats a level or addresses a missing pin, the level bank readback, the reset contents, and the precedence between same-cycle sources.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_LVL  = 2'd0,
    SEL_PIN  = 2'd1,
    SEL_NONE = 2'd2
  } sel_e;

  localparam int BIT_OE  = 2;
  localparam int BIT_LVL = 1;
  localparam int BIT_DO  = 0;
  localparam int BYTE_W  = 8;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int NUM_LVL  = 8,
  parameter int NUM_PINS = 36
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [ADDR_W-1:0] idx
);
  localparam logic [ADDR_W-1:0] PIN_BASE = ADDR_W'(NUM_LVL);
  localparam logic [ADDR_W-1:0] PIN_END  = ADDR_W'(NUM_LVL + NUM_PINS);

  always_comb begin
    if (addr < PIN_BASE) begin
      sel = SEL_LVL;
      idx = addr;
    end else if (addr < PIN_END) begin
      sel = SEL_PIN;
      idx = addr - PIN_BASE;
    end else begin
      sel = SEL_NONE;
      idx = '0;
    end
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_pkg::*;
#(
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_hit,
  input  logic [7:0] wdata,
  input  logic       pulse_set,
  input  logic       pulse_clr,
  input  logic       ev_hit,
  input  logic       ev_val,
  output logic [7:0] q,
  output logic       ev_err
);
  logic [7:0] wr_byte;

  always_comb begin
    wr_byte          = wdata;
    wr_byte[BIT_LVL] = wdata[BIT_OE] ? wdata[BIT_DO] : q[BIT_LVL];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (wr_hit) begin
      q <= wr_byte;
    end else if (pulse_set) begin
      q[BIT_LVL] <= 1'b1;
    end else if (pulse_clr) begin
      q[BIT_LVL] <= 1'b0;
    end else if (ev_hit) begin
      q[BIT_LVL] <= ev_val;
    end
  end

  assign ev_err = ev_hit & q[BIT_OE];
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int NUM_LVL  = 8,
  parameter int NUM_PINS = 36
) (
  input  sel_e                   sel,
  input  logic [ADDR_W-1:0]      idx,
  input  logic [NUM_LVL*8-1:0]   lvl_bank,
  input  logic [7:0]             pin_q [NUM_PINS],
  output logic [7:0]             data
);
  always_comb begin
    data = '0;
    if (sel == SEL_LVL) begin
      for (int k = 0; k < NUM_LVL; k++) begin
        if (idx == ADDR_W'(k)) data = lvl_bank[k*8 +: 8];
      end
    end else if (sel == SEL_PIN) begin
      for (int k = 0; k < NUM_PINS; k++) begin
        if (idx == ADDR_W'(k)) data = pin_q[k];
      end
    end
  end
endmodule

// File: rtl/gpio_pinctl.sv
module gpio_pinctl
  import gpio_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_LVL   = 8,
  parameter int NUM_PINS  = 36,
  parameter int LOW_PIN   = 1,
  parameter int PULSE_PIN = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  logic [NUM_LVL*8-1:0]  lvl_bank,
  input  logic                  in_set,
  input  logic [ADDR_W-1:0]     in_pin,
  input  logic                  in_val,
  input  logic                  nmi_req,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [NUM_PINS-1:0]   pin_do,
  output logic                  irq_low,
  output logic                  irq_nmi,
  output logic                  err_flag
);
  sel_e              sel;
  logic [ADDR_W-1:0] idx;
  logic [7:0]        pin_q [NUM_PINS];
  logic [NUM_PINS-1:0] err_vec;
  logic [7:0]        rd_data;
  logic              pulse_st;
  logic              pulse_set;

  gpio_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_LVL(NUM_LVL), .NUM_PINS(NUM_PINS)
  ) u_dec (
    .addr(bus_addr), .sel(sel), .idx(idx)
  );

  assign pulse_set = nmi_req & ~pulse_st;

  always_ff @(posedge clk) begin
    if (rst) pulse_st <= 1'b0;
    else     pulse_st <= pulse_set;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam logic [7:0] RV = (i == LOW_PIN) ? 8'h02 : 8'h00;
    logic wr_hit, ev_hit, p_set, p_clr;

    assign wr_hit = bus_wr && (sel == SEL_PIN) && (idx == ADDR_W'(i));
    assign ev_hit = in_set && (in_pin == ADDR_W'(i));

    if (i == PULSE_PIN) begin : g_nmi
      assign p_set = pulse_set;
      assign p_clr = pulse_st;
    end else begin : g_plain
      assign p_set = 1'b0;
      assign p_clr = 1'b0;
    end

    gpio_pin_cell #(.RST_VAL(RV)) u_cell (
      .clk(clk), .rst(rst), .wr_hit(wr_hit), .wdata(bus_wdata),
      .pulse_set(p_set), .pulse_clr(p_clr),
      .ev_hit(ev_hit), .ev_val(in_val),
      .q(pin_q[i]), .ev_err(err_vec[i])
    );

    assign pin_oe[i] = pin_q[i][BIT_OE];
    assign pin_do[i] = pin_q[i][BIT_DO];
  end

  gpio_rd_mux #(
    .ADDR_W(ADDR_W), .NUM_LVL(NUM_LVL), .NUM_PINS(NUM_PINS)
  ) u_mux (
    .sel(sel), .idx(idx), .lvl_bank(lvl_bank), .pin_q(pin_q), .data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      err_flag  <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_data;
      if (|err_vec) err_flag <= 1'b1;
    end
  end

  assign irq_low = ~pin_q[LOW_PIN][BIT_LVL];
  assign irq_nmi = pin_q[PULSE_PIN][BIT_LVL];
endmodule

// File: rtl/gpio_pinctl_chk.sv
module gpio_pinctl_chk #(
  parameter int ADDR_W    = 6,
  parameter int NUM_LVL   = 8,
  parameter int NUM_PINS  = 36,
  parameter int LOW_PIN   = 1,
  parameter int PULSE_PIN = 9
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [7:0]          bus_wdata,
  input logic [7:0]          bus_rdata,
  input logic                nmi_req,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_do,
  input logic                irq_low,
  input logic                irq_nmi,
  input logic                err_flag
);
  localparam logic [ADDR_W-1:0] A_LOW   = ADDR_W'(NUM_LVL + LOW_PIN);
  localparam logic [ADDR_W-1:0] A_PULSE = ADDR_W'(NUM_LVL + PULSE_PIN);
  localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(NUM_LVL);
  localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(NUM_LVL + NUM_PINS);

  logic wr_pulse;
  assign wr_pulse = bus_wr && (bus_addr == A_PULSE);

  p_lvl_ro_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr < A_BASE) |=> ($stable(pin_oe) && $stable(pin_do)));

  p_low_loop_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_LOW && bus_wdata[2]) |=> (irq_low == !$past(bus_wdata[0])));

  p_pulse_loop_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_pulse && bus_wdata[2]) |=> (irq_nmi == $past(bus_wdata[0])));

  p_pulse_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_nmi && $past(nmi_req) && !$past(wr_pulse)) |=> (!irq_nmi || $past(wr_pulse)));

  p_tail_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr >= A_END) |=> (bus_rdata == 8'h00));

  p_tail_ro_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr >= A_END) |=> ($stable(pin_oe) && $stable(pin_do)));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !$fell(err_flag));
endmodule

bind gpio_pinctl gpio_pinctl_chk #(
  .ADDR_W(ADDR_W), .NUM_LVL(NUM_LVL), .NUM_PINS(NUM_PINS),
  .LOW_PIN(LOW_PIN), .PULSE_PIN(PULSE_PIN)
) u_chk (.*);

// File: tb/sim_gpio_pinctl.sv
`timescale 1ns/1ps
module sim_gpio_pinctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [63:0] lvl_bank;
  logic        in_set = 1'b0;
  logic [5:0]  in_pin = '0;
  logic        in_val = 1'b0;
  logic        nmi_req = 1'b0;
  logic [35:0] pin_oe, pin_do;
  logic        irq_low, irq_nmi, err_flag;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  for (genvar k = 0; k < 8; k++) begin : g_lvl
    assign lvl_bank[k*8 +: 8] = 8'h30 + 8'(k * 7);
  end

  gpio_pinctl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lvl_bank(lvl_bank),
    .in_set(in_set), .in_pin(in_pin), .in_val(in_val), .nmi_req(nmi_req),
    .pin_oe(pin_oe), .pin_do(pin_do), .irq_low(irq_low), .irq_nmi(irq_nmi),
    .err_flag(err_flag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ev(input logic [5:0] p, input logic v);
    @(negedge clk);
    in_pin = p; in_val = v; in_set = 1'b1;
    @(negedge clk);
    in_set = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 irq_low", 64'(irq_low), 64'd0);
    chk("R1 irq_nmi", 64'(irq_nmi), 64'd0);
    chk("R1 err_flag", 64'(err_flag), 64'd0);
    chk("R1 pin_oe", 64'(pin_oe), 64'd0);
    chk("R1 pin_do", 64'(pin_do), 64'd0);
    for (int p = 0; p < 36; p++) begin
      rd(6'(8 + p), d);
      chk("R1 R3 reset byte", 64'(d), (p == 1) ? 64'h02 : 64'h00);
    end
  endtask

  task automatic t_level_bank;
    logic [7:0] d;
    for (int k = 0; k < 8; k++) begin
      rd(6'(k), d);
      chk("R2 level read", 64'(d), 64'(8'h30 + 8'(k * 7)));
    end
    wr(6'd3, 8'hFF);
    wr(6'd0, 8'h05);
    chk("R2 write ignored oe", 64'(pin_oe), 64'd0);
    chk("R2 write ignored do", 64'(pin_do), 64'd0);
    rd(6'd3, d);
    chk("R2 level after write", 64'(d), 64'h45);
    rd(6'd9, d);
    chk("R2 pin1 untouched", 64'(d), 64'h02);
  endtask

  task automatic t_write;
    logic [7:0] d;
    wr(6'd12, 8'hA5);
    rd(6'd12, d);
    chk("R4 loopback set", 64'(d), 64'hA7);
    chk("R4 pin_oe", 64'(pin_oe[4]), 64'd1);
    chk("R4 pin_do", 64'(pin_do[4]), 64'd1);
    wr(6'd12, 8'h10);
    rd(6'd12, d);
    chk("R4 keep level", 64'(d), 64'h12);
    wr(6'd12, 8'h04);
    rd(6'd12, d);
    chk("R4 loopback clear", 64'(d), 64'h04);
    wr(6'd12, 8'h0A);
    rd(6'd12, d);
    chk("R4 bit1 discarded", 64'(d), 64'h08);
    wr(6'd43, 8'h05);
    rd(6'd43, d);
    chk("R3 R4 last pin", 64'(d), 64'h07);
    @(negedge clk);
    chk("R3 rdata holds", 64'(bus_rdata), 64'h07);
  endtask

  task automatic t_event;
    logic [7:0] d;
    ev(6'd6, 1'b1);
    rd(6'd14, d);
    chk("R5 event set", 64'(d), 64'h02);
    ev(6'd6, 1'b1);
    rd(6'd14, d);
    chk("R5 event same level", 64'(d), 64'h02);
    ev(6'd6, 1'b0);
    rd(6'd14, d);
    chk("R5 event clear", 64'(d), 64'h00);
    wr(6'd15, 8'hF0);
    ev(6'd7, 1'b1);
    rd(6'd15, d);
    chk("R5 only bit1", 64'(d), 64'hF2);
    ev(6'd40, 1'b1);
    ev(6'd63, 1'b1);
    rd(6'd15, d);
    chk("R5 out of range pin7", 64'(d), 64'hF2);
    rd(6'd43, d);
    chk("R5 out of range pin35", 64'(d), 64'h07);
    chk("R5 no error", 64'(err_flag), 64'd0);
  endtask

  task automatic t_irq_low;
    logic [7:0] d;
    ev(6'd1, 1'b0);
    chk("R6 low asserted", 64'(irq_low), 64'd1);
    ev(6'd1, 1'b1);
    chk("R6 low released", 64'(irq_low), 64'd0);
    wr(6'd9, 8'h04);
    chk("R6 loopback low", 64'(irq_low), 64'd1);
    wr(6'd9, 8'h00);
    chk("R6 keep low", 64'(irq_low), 64'd1);
    wr(6'd9, 8'h05);
    chk("R6 loopback high", 64'(irq_low), 64'd0);
    wr(6'd9, 8'h00);
    rd(6'd9, d);
    chk("R6 byte", 64'(d), 64'h02);
  endtask

  task automatic t_nmi;
    logic [7:0] d;
    @(negedge clk);
    nmi_req = 1'b1;
    @(negedge clk);
    nmi_req = 1'b0;
    chk("R8 pulse high", 64'(irq_nmi), 64'd1);
    @(negedge clk);
    chk("R8 pulse low", 64'(irq_nmi), 64'd0);
    rd(6'd17, d);
    chk("R8 pin9 byte", 64'(d), 64'h00);
    ev(6'd9, 1'b1);
    chk("R7 follows level", 64'(irq_nmi), 64'd1);
    ev(6'd9, 1'b0);
    chk("R7 follows low", 64'(irq_nmi), 64'd0);
  endtask

  task automatic t_tail;
    logic [7:0] d;
    logic [35:0] oe0, do0;
    for (int a = 44; a < 48; a++) begin
      rd(6'(a), d);
      chk("R9 tail read", 64'(d), 64'h00);
    end
    oe0 = pin_oe; do0 = pin_do;
    wr(6'd46, 8'hFF);
    wr(6'd63, 8'hFF);
    chk("R9 tail write oe", 64'(pin_oe), 64'(oe0));
    chk("R9 tail write do", 64'(pin_do), 64'(do0));
    rd(6'd46, d);
    chk("R9 tail after write", 64'(d), 64'h00);
  endtask

  task automatic t_err;
    logic [7:0] d;
    chk("R10 clear before", 64'(err_flag), 64'd0);
    wr(6'd11, 8'h05);
    ev(6'd3, 1'b0);
    chk("R10 raised", 64'(err_flag), 64'd1);
    rd(6'd11, d);
    chk("R10 level still updated", 64'(d), 64'h05);
    wr(6'd11, 8'h00);
    ev(6'd20, 1'b1);
    chk("R10 sticky", 64'(err_flag), 64'd1);
  endtask

  task automatic t_prio;
    logic [7:0] d;
    ev(6'd5, 1'b0);
    @(negedge clk);
    bus_addr = 6'd13; bus_wdata = 8'h30; bus_wr = 1'b1;
    in_pin = 6'd5; in_val = 1'b1; in_set = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; in_set = 1'b0;
    rd(6'd13, d);
    chk("R11 write beats event", 64'(d), 64'h30);
    @(negedge clk);
    nmi_req = 1'b1;
    in_pin = 6'd9; in_val = 1'b0; in_set = 1'b1;
    @(negedge clk);
    nmi_req = 1'b0;
    in_val = 1'b1;
    chk("R11 pulse set beats event", 64'(irq_nmi), 64'd1);
    @(negedge clk);
    in_set = 1'b0;
    chk("R11 pulse clear beats event", 64'(irq_nmi), 64'd0);
    @(negedge clk);
    nmi_req = 1'b1;
    @(negedge clk);
    nmi_req = 1'b0;
    bus_addr = 6'd17; bus_wdata = 8'h05; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R11 write beats pulse clear", 64'(irq_nmi), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_level_bank();
    t_write();
    t_event();
    t_irq_low();
    t_nmi();
    t_tail();
    t_err();
    t_prio();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule